// File: doc/BRIEF.md
# Hall Commutation and PWM Gate Controller

This block drives a three-phase brushless motor. It reads three digitized Hall sensor bits and a direction select, and from them it picks one leg to source current and one leg to sink it. It then produces gate enables for the upper and lower switch of each of the three half-bridges. Only the sourcing leg is chopped, and only on its upper switch. While that upper switch is off, the lower switch of the same leg conducts, which gives synchronous rectification.

The PWM command is high while the external carrier count is below the duty word. A current-limit comparator can end an on-period early. A trip counts only after a blanking window that starts at the rising edge of the command. A protection flag removes all upper drive. The start/stop input stops the motor in one of two ways: coasting with every switch open, or braking with every lower switch closed. A per-leg dead-time guard makes sure no switch closes until its leg has been fully open for a set number of clocks.

All gate outputs are registered.

Top module: `motor_commutator`

## Requirements
- R1: With start_ni high and brake_ni high, all six gate outputs are low.
- R2: With start_ni high and brake_ni low, lo_o is 3'b111 and hi_o is 3'b000.
- R3: With fwd_i high and start_ni low, the Hall code {hall_i[2],hall_i[1],hall_i[0]} selects the sourcing leg (upper) and the sinking leg (lower) as follows:
  - 101 gives source 1, sink 0.
  - 001 gives source 2, sink 0.
  - 011 gives source 2, sink 1.
  - 010 gives source 0, sink 1.
  - 110 gives source 0, sink 2.
  - 100 gives source 1, sink 2.
  - The third leg has both switches open. Bit n of hi_o and lo_o is leg n.
- R4: With fwd_i low, the bitwise complement of hall_i is looked up in the R3 table.
- R5: The sourcing leg closes its upper switch while the PWM command (carrier_i < duty_i, not tripped) is high. While the command is low it closes its lower switch instead. The sinking leg keeps its lower switch closed, and at most one upper switch is ever on.
- R6: A switch closes only after its leg has had both switches open for DEAD_CYC consecutive clocks. Moving a leg from one switch to the other therefore opens it at the first edge and closes the new switch DEAD_CYC edges later. The two switches of a leg are never on together.
- R7: A current-limit trip holds the PWM command low until the command itself falls at the end of the period, even if ilim_i drops first.
- R8: ilim_i is ignored during the first BLANK_CYC clocks after the PWM command rises. With ilim_i held high, the trip is taken on the clock edge numbered BLANK_CYC+1 after the command rises.
- R9: While prot_i is high, all upper switches are open. The sourcing leg idles with both switches open, and the sinking leg keeps its lower switch closed.
- R10: While running, the Hall codes 000 and 111 open all six switches.
- R11: While stopped, hall_i, fwd_i and duty_i have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hall_i | input | 3 | Digitized Hall sensor bits, bit n from sensor n |
| fwd_i | input | 1 | Direction select, high for forward |
| start_ni | input | 1 | Low runs the motor, high stops it |
| brake_ni | input | 1 | Stop style: low brakes, high coasts |
| carrier_i | input | CW | PWM carrier count |
| duty_i | input | CW | PWM duty word |
| ilim_i | input | 1 | Current-limit comparator flag |
| prot_i | input | 1 | Protection flag, forces upper switches off |
| hi_o | output | 3 | Upper switch enables, bit n is leg n |
| lo_o | output | 3 | Lower switch enables, bit n is leg n |

## Verification
The inputs feed a single register stage, so a change that needs no dead-time wait appears on the gates one edge later. A leg that changes sides opens at that edge and closes the new switch DEAD_CYC edges after it. A current-limit trip adds one edge, because the trip is registered before it reaches the leg request. The bench counts rising edges from the falling edge at which it changes an input. For each result it queues the edge count on which that result is due, and it checks just before the deadline (DEAD_CYC, BLANK_CYC+1) as well as on it, so a result that comes one edge early is caught.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int NLEG = 3;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_req_e;
endpackage

// File: rtl/mc_hall_decode.sv
module mc_hall_decode (
  input  logic [2:0] hall_i,
  input  logic       fwd_i,
  output logic       valid_o,
  output logic [1:0] src_o,
  output logic [1:0] snk_o
);
  logic [2:0] code;

  // reverse rotation looks up the complemented sensor code
  assign code = fwd_i ? hall_i : ~hall_i;

  always_comb begin
    valid_o = 1'b1;
    src_o   = 2'd0;
    snk_o   = 2'd0;
    unique case (code)
      3'b101: begin src_o = 2'd1; snk_o = 2'd0; end
      3'b001: begin src_o = 2'd2; snk_o = 2'd0; end
      3'b011: begin src_o = 2'd2; snk_o = 2'd1; end
      3'b010: begin src_o = 2'd0; snk_o = 2'd1; end
      3'b110: begin src_o = 2'd0; snk_o = 2'd2; end
      3'b100: begin src_o = 2'd1; snk_o = 2'd2; end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mc_pwm_gate.sv
module mc_pwm_gate #(
  parameter int CW        = 8,
  parameter int BLANK_CYC = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] carrier_i,
  input  logic [CW-1:0] duty_i,
  input  logic          ilim_i,
  output logic          pwm_on_o
);
  localparam int BW = $clog2(BLANK_CYC + 2);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);

  logic          cmd;
  logic [BW-1:0] blank_q;
  logic          trip_q;

  assign cmd = carrier_i < duty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q <= '0;
      trip_q  <= 1'b0;
    end else if (!cmd) begin
      blank_q <= '0;
      trip_q  <= 1'b0;
    end else begin
      if (blank_q != BLANK_END) blank_q <= blank_q + 1'b1;
      if (ilim_i && blank_q == BLANK_END) trip_q <= 1'b1;
    end
  end

  assign pwm_on_o = cmd & ~trip_q;
endmodule

// File: rtl/mc_leg_drive.sv
module mc_leg_drive
  import mc_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  leg_req_e req_i,
  output logic     hi_o,
  output logic     lo_o
);
  localparam int CNTW = $clog2(DEAD_CYC + 2);
  localparam logic [CNTW-1:0] DEAD_END = CNTW'(DEAD_CYC);

  logic            hi_q, lo_q, hi_d, lo_d;
  logic [CNTW-1:0] idle_q;
  logic            gap_ok;

  assign gap_ok = !hi_q && !lo_q && idle_q >= DEAD_END;

  always_comb begin
    hi_d = 1'b0;
    lo_d = 1'b0;
    case (req_i)
      LEG_HI:  hi_d = hi_q || gap_ok;
      LEG_LO:  lo_d = lo_q || gap_ok;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      idle_q <= DEAD_END;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      if (hi_d || lo_d)          idle_q <= '0;
      else if (idle_q != DEAD_END) idle_q <= idle_q + 1'b1;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/motor_commutator.sv
module motor_commutator
  import mc_pkg::*;
#(
  parameter int CW        = 8,
  parameter int DEAD_CYC  = 4,
  parameter int BLANK_CYC = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    hall_i,
  input  logic          fwd_i,
  input  logic          start_ni,
  input  logic          brake_ni,
  input  logic [CW-1:0] carrier_i,
  input  logic [CW-1:0] duty_i,
  input  logic          ilim_i,
  input  logic          prot_i,
  output logic [2:0]    hi_o,
  output logic [2:0]    lo_o
);
  logic       pwm_on;
  logic       hall_ok;
  logic [1:0] src_idx, snk_idx;

  mc_pwm_gate #(.CW(CW), .BLANK_CYC(BLANK_CYC)) u_pwm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .carrier_i (carrier_i),
    .duty_i    (duty_i),
    .ilim_i    (ilim_i),
    .pwm_on_o  (pwm_on)
  );

  mc_hall_decode u_dec (
    .hall_i  (hall_i),
    .fwd_i   (fwd_i),
    .valid_o (hall_ok),
    .src_o   (src_idx),
    .snk_o   (snk_idx)
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    leg_req_e req;

    always_comb begin
      if (start_ni)                  req = brake_ni ? LEG_OFF : LEG_LO;
      else if (!hall_ok)             req = LEG_OFF;
      else if (snk_idx == 2'(g))     req = LEG_LO;
      else if (src_idx == 2'(g))     req = prot_i ? LEG_OFF : (pwm_on ? LEG_HI : LEG_LO);
      else                           req = LEG_OFF;
    end

    mc_leg_drive #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req),
      .hi_o   (hi_o[g]),
      .lo_o   (lo_o[g])
    );
  end
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
  parameter int DEAD_CYC = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] hall_i,
  input logic       start_ni,
  input logic       brake_ni,
  input logic       prot_i,
  input logic [2:0] hi_o,
  input logic [2:0] lo_o
);
  localparam int RW = $clog2(DEAD_CYC + 2);
  localparam logic [RW-1:0] GAP = RW'(DEAD_CYC);

  AST_LEG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_o & lo_o) == 3'b000);                                                    // R6

  AST_ONE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hi_o));                                                             // R5

  AST_COAST_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ni && brake_ni |=> hi_o == 3'b000 && lo_o == 3'b000);                 // R1

  AST_BRAKE_NO_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ni && !brake_ni |=> hi_o == 3'b000);                                   // R2

  AST_PROT_UPPER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_i |=> hi_o == 3'b000);                                                  // R9

  AST_BAD_HALL_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_ni && (hall_i == 3'b000 || hall_i == 3'b111)
      |=> hi_o == 3'b000 && lo_o == 3'b000);                                     // R10

  for (genvar g = 0; g < 3; g++) begin : g_gap
    logic [RW-1:0] open_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    open_run <= GAP;
      else if (hi_o[g] || lo_o[g])    open_run <= '0;
      else if (open_run != GAP)       open_run <= open_run + 1'b1;
    end

    AST_DEAD_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hi_o[g]) |-> open_run >= GAP);                                       // R6

    AST_DEAD_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lo_o[g]) |-> open_run >= GAP);                                       // R6
  end
endmodule

bind motor_commutator mc_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hall_i   (hall_i),
  .start_ni (start_ni),
  .brake_ni (brake_ni),
  .prot_i   (prot_i),
  .hi_o     (hi_o),
  .lo_o     (lo_o)
);

// File: tb/tb_motor_commutator.sv
`timescale 1ns/1ps
module tb_motor_commutator;
  localparam int CW = 8;
  localparam int DC = 4;
  localparam int BC = 15;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    hall = 3'b101;
  logic          fwd = 1'b1, start_n = 1'b1, brake_n = 1'b1;
  logic [CW-1:0] carrier = '0, duty = '0;
  logic          ilim = 1'b0, prot = 1'b0;
  logic [2:0]    hi, lo;

  motor_commutator #(.CW(CW), .DEAD_CYC(DC), .BLANK_CYC(BC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .hall_i(hall), .fwd_i(fwd),
    .start_ni(start_n), .brake_ni(brake_n), .carrier_i(carrier),
    .duty_i(duty), .ilim_i(ilim), .prot_i(prot), .hi_o(hi), .lo_o(lo)
  );

  always #10 clk = ~clk;

  typedef struct {
    int       due;
    logic [2:0] hi;
    logic [2:0] lo;
    string    tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops due items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (hi !== e.hi || lo !== e.lo) begin
          bad++;
          $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", e.tag, hi, lo, e.hi, e.lo);
        end
      end
    end
  end

  task automatic expect_in(input int n, input logic [2:0] h, input logic [2:0] l, input string tag);
    exp_t e;
    e.due = cyc + n;
    e.hi  = h;
    e.lo  = l;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    expect_in(0, 3'b000, 3'b000, "R1 reset coast");
    idle(2);

    brake_n = 1'b0;
    expect_in(1, 3'b000, 3'b111, "R2 brake all lower");
    idle(3);
    brake_n = 1'b1;
    expect_in(1, 3'b000, 3'b000, "R1 coast all open");
    idle(8);

    start_n = 1'b0; duty = 8'd1;
    expect_in(1, 3'b010, 3'b001, "R3 fwd 101");
    idle(8);
    hall = 3'b001;
    expect_in(1, 3'b100, 3'b001, "R3 fwd 001");
    idle(8);
    hall = 3'b011;
    expect_in(1, 3'b100, 3'b010, "R3 fwd 011");
    idle(8);

    fwd = 1'b0;
    expect_in(1,    3'b000, 3'b000, "R6 legs open first");
    expect_in(DC,   3'b000, 3'b000, "R6 still in dead time");
    expect_in(DC+1, 3'b010, 3'b100, "R4 reverse 011");
    idle(DC+3);

    duty = 8'd0;
    expect_in(1,    3'b000, 3'b100, "R5 upper opens");
    expect_in(DC+1, 3'b000, 3'b110, "R5 sync rectify lower");
    idle(DC+3);
    duty = 8'd1;
    expect_in(DC,   3'b000, 3'b100, "R6 gap before upper");
    expect_in(DC+1, 3'b010, 3'b100, "R5 upper back on");
    idle(30);

    ilim = 1'b1;
    expect_in(1,    3'b010, 3'b100, "R7 trip registered first");
    expect_in(2,    3'b000, 3'b100, "R7 trip ends on-time");
    expect_in(DC+2, 3'b000, 3'b110, "R7 rectify after trip");
    idle(DC+3);
    ilim = 1'b0;
    expect_in(3, 3'b000, 3'b110, "R7 trip held to period end");
    idle(4);
    duty = 8'd0;
    idle(4);
    duty = 8'd1; ilim = 1'b1;
    expect_in(DC+1, 3'b010, 3'b100, "R8 upper on while blanked");
    expect_in(BC+1, 3'b010, 3'b100, "R8 blank window holds");
    expect_in(BC+2, 3'b000, 3'b100, "R8 trip after blanking");
    idle(BC+3);
    ilim = 1'b0; duty = 8'd0;
    idle(10);
    duty = 8'd1;
    expect_in(DC+1, 3'b010, 3'b100, "R7 new period clears trip");
    idle(DC+3);

    prot = 1'b1;
    expect_in(1, 3'b000, 3'b100, "R9 protect opens upper");
    idle(8);
    prot = 1'b0;
    expect_in(1, 3'b010, 3'b100, "R9 protect release");
    idle(4);

    hall = 3'b111;
    expect_in(1, 3'b000, 3'b000, "R10 hall 111");
    idle(3);
    hall = 3'b000;
    expect_in(1, 3'b000, 3'b000, "R10 hall 000");
    idle(8);
    hall = 3'b011;
    expect_in(1, 3'b010, 3'b100, "R4 valid again");
    idle(8);

    start_n = 1'b1; brake_n = 1'b0;
    expect_in(1,    3'b000, 3'b101, "R2 brake open upper");
    expect_in(DC+1, 3'b000, 3'b111, "R2 brake all lower");
    idle(DC+3);
    hall = 3'b000; fwd = 1'b1; duty = 8'd0;
    expect_in(1, 3'b000, 3'b111, "R11 stop ignores hall");
    idle(3);
    hall = 3'b010; duty = 8'd9;
    expect_in(2, 3'b000, 3'b111, "R11 stop ignores duty");
    idle(4);
    brake_n = 1'b1;
    expect_in(1, 3'b000, 3'b000, "R1 coast after brake");
    idle(4);

    if (q.size() != 0) begin
      bad++;
      $display("FAIL R1: %0d queued checks left, expected 0", q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1: watchdog expired, actual hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule